// File: doc/BRIEF.md
# CRC-16 CCITT Accumulator Engine

This block keeps a running 16-bit cyclic redundancy check that a host processor feeds through a small write port. The host first writes a 16-bit starting value, then writes data words one after another; each word is folded into the running value using the generator x^16 + x^12 + x^5 + 1 (0x1021). Every data write carries its own width code, so 1-bit, 8-bit, 16-bit and 32-bit words may be mixed freely in one stream without reseeding. The running value is always visible on the result port.

Bits are taken most significant first from the low bits of the write data. No bit reflection is applied on input or output, and the result is not inverted or XORed at the end. A parameter selects between a single-cycle parallel fold and a one-bit-per-cycle serial fold. The serial fold uses much less logic. It shows that it is busy through a ready output.

Top module: `crc16_acc`

## Requirements
- R1: After reset the result port shows the RESET_VAL parameter (default 16'hFFFF) and ready_o is high.
- R2: Data is folded with generator 0x1021, most significant bit first, with no reflection and no final XOR. From a start value of 16'hFFFF, the ASCII bytes "123456789" give 16'h29B1.
- R3: wr_width selects how many low bits of wr_data are folded: 2'b00 = 1 bit (wr_data[0]), 2'b01 = 8 bits, 2'b10 = 16 bits, 2'b11 = 32 bits. The unselected upper bits have no effect.
- R4: Consecutive data writes of different widths chain into the same running value. A 32-bit write equals four 8-bit writes of its bytes, highest byte first.
- R5: A write with wr_sel = 1 loads wr_data[15:0] as the running value, and crc_o shows it in the cycle after the write. It also cancels any serial fold in progress, and ready_o is high in that cycle.
- R6: In the parallel variant (SERIAL = 0), the result of a data write appears on crc_o in the cycle after the write, and ready_o stays high.
- R7: With wr_en low and no fold in progress, crc_o holds its value.
- R8: In the serial variant (SERIAL = 1), an n-bit data write folds one bit per cycle, starting in the write cycle. ready_o is low for n-1 cycles after the write, so a 1-bit write never drops ready_o.
- R9: In the serial variant, data writes made while ready_o is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 1 = load start value, 0 = fold data |
| wr_width | input | 2 | Data width code (see R3) |
| wr_data | input | 32 | Write data; start value in bits 15:0 |
| crc_o | output | 16 | Running CRC value |
| ready_o | output | 1 | High when a new data write is accepted |

## Verification
The parallel fold and the start-value load are due on crc_o one clock after the write edge. The bench drives each write on a falling edge and samples at the next falling edge, exactly one rising edge later. The serial instance is sampled only after ready_o returns high. The cycles spent waiting are counted, and that count is checked against n-1 for an n-bit word. The writes made while busy and the start-value loads that cancel a fold are timed at falling edges inside that busy window. Each check then waits for the edge on which its result is due.

// File: rtl/crc16_acc_pkg.sv
package crc16_acc_pkg;

    localparam logic [15:0] CCITT_POLY = 16'h1021;

    typedef enum logic [1:0] {
        WID_1  = 2'b00,
        WID_8  = 2'b01,
        WID_16 = 2'b10,
        WID_32 = 2'b11
    } wid_code_e;

    // number of data bits folded for a width code
    function automatic int wid_bits(input logic [1:0] code);
        case (code)
            WID_1:   return 1;
            WID_8:   return 8;
            WID_16:  return 16;
            default: return 32;
        endcase
    endfunction

    // one shift of the LFSR with one incoming data bit
    function automatic logic [15:0] crc_shift1(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CCITT_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/crc16_fold.sv
module crc16_fold
    import crc16_acc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [15:0]       crc_in,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        width,
    output logic [15:0]       crc_out
);

    always_comb begin
        logic [15:0] c;
        int          n;
        c = crc_in;
        n = wid_bits(width);
        for (int j = DATA_W - 1; j >= 0; j--) begin
            if (j < n) begin
                c = crc_shift1(c, data[j]);
            end
        end
        crc_out = c;
    end

    // R2: the fold is linear, so zero data on a zero value stays zero
    always_comb begin
        if (crc_in == 16'h0000 && data == '0) begin
            a_r2_zero_fixed: assert (crc_out == 16'h0000);
        end
    end

endmodule

// File: rtl/crc16_serial_core.sv
module crc16_serial_core
    import crc16_acc_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [15:0] RESET_VAL = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_seed,
    input  logic              ld_data,
    input  logic [1:0]        width,
    input  logic [DATA_W-1:0] data,
    output logic [15:0]       crc,
    output logic              busy
);

    localparam int CW = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [15:0]       crc;
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     cnt;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        logic [DATA_W-1:0] al;
        int                n;
        st_d = st_q;
        n    = wid_bits(width);
        al   = data << (DATA_W - n);
        if (ld_seed) begin
            st_d.crc = data[15:0];
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (st_q.cnt != '0) begin
            st_d.crc = crc_shift1(st_q.crc, st_q.sh[DATA_W-1]);
            st_d.sh  = st_q.sh << 1;
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (ld_data) begin
            st_d.crc = crc_shift1(st_q.crc, al[DATA_W-1]);
            st_d.sh  = al << 1;
            st_d.cnt = CW'(n - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.crc <= RESET_VAL;
            st_q.sh  <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc  = st_q.crc;
    assign busy = (st_q.cnt != '0);

    // R9: a data write while busy does not restart the count
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_data && !ld_seed) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R8: a multi-bit word accepted while idle makes the core busy
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ld_data && !ld_seed && width != WID_1) |=> busy);

endmodule

// File: rtl/crc16_acc.sv
module crc16_acc
    import crc16_acc_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [15:0] RESET_VAL = 16'hFFFF,
    parameter bit          SERIAL    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [1:0]        wr_width,
    input  logic [DATA_W-1:0] wr_data,
    output logic [15:0]       crc_o,
    output logic              ready_o
);

    logic ld_seed, ld_data;
    assign ld_seed = wr_en && wr_sel;
    assign ld_data = wr_en && !wr_sel;

    generate
        if (SERIAL) begin : g_serial
            logic ser_busy;
            crc16_serial_core #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) core_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .ld_seed (ld_seed),
                .ld_data (ld_data),
                .width   (wr_width),
                .data    (wr_data),
                .crc     (crc_o),
                .busy    (ser_busy)
            );
            assign ready_o = !ser_busy;
        end else begin : g_parallel
            typedef struct packed {
                logic [15:0] crc;
            } par_st_t;

            par_st_t     st_d, st_q;
            logic [15:0] folded;

            crc16_fold #(.DATA_W(DATA_W)) fold_i (
                .crc_in  (st_q.crc),
                .data    (wr_data),
                .width   (wr_width),
                .crc_out (folded)
            );

            always_comb begin
                st_d = st_q;
                if (ld_seed) begin
                    st_d.crc = wr_data[15:0];
                end else if (ld_data) begin
                    st_d.crc = folded;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q.crc <= RESET_VAL;
                end else begin
                    st_q <= st_d;
                end
            end

            assign crc_o   = st_q.crc;
            assign ready_o = 1'b1;
        end
    endgenerate

    // R5: a start-value write shows on the result port one cycle later
    a_r5_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (crc_o == $past(wr_data[15:0]) && ready_o));

    // R7: with no write and no fold in progress the value holds
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ready_o) |=> $stable(crc_o));

endmodule

// File: tb/crc16_acc_tb_top.sv
module crc16_acc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0]  wr_width = 2'b00;
    logic [31:0] wr_data = '0;
    logic        s_wr_en = 1'b0, s_wr_sel = 1'b0;
    logic [1:0]  s_wr_width = 2'b00;
    logic [31:0] s_wr_data = '0;
    logic [15:0] crc_o, s_crc_o;
    logic        ready_o, s_ready_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    crc16_acc #(.SERIAL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_width(wr_width), .wr_data(wr_data), .crc_o(crc_o), .ready_o(ready_o)
    );

    crc16_acc #(.SERIAL(1'b1)) ser_i (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_sel(s_wr_sel),
        .wr_width(s_wr_width), .wr_data(s_wr_data), .crc_o(s_crc_o), .ready_o(s_ready_o)
    );

    // stimulus table: {sel, width code, data}
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 2'b00, 32'h0000FFFF},
        {1'b0, 2'b01, 32'h00000031},
        {1'b0, 2'b00, 32'h00000001},
        {1'b0, 2'b10, 32'h0000ABCD},
        {1'b0, 2'b11, 32'hDEADBEEF},
        {1'b0, 2'b01, 32'hFFFFFF5A},
        {1'b1, 2'b00, 32'hABCD0000},
        {1'b0, 2'b11, 32'h00000000},
        {1'b0, 2'b10, 32'h77771021},
        {1'b0, 2'b00, 32'hFFFFFFFE},
        {1'b1, 2'b00, 32'h00001D0F},
        {1'b0, 2'b01, 32'h00000000}
    };

    function automatic logic [15:0] model(input logic [15:0] c, input logic [31:0] d,
                                          input logic [1:0] code);
        int n;
        logic fb;
        n = (code == 2'b00) ? 1 : (code == 2'b01) ? 8 : (code == 2'b10) ? 16 : 32;
        for (int i = n - 1; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pwr(input logic sel, input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_width = w; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic s_issue(input logic sel, input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        s_wr_en = 1'b1; s_wr_sel = sel; s_wr_width = w; s_wr_data = d;
        @(negedge clk);
        s_wr_en = 1'b0;
    endtask

    task automatic s_wait(output int cyc);
        cyc = 0;
        while (!s_ready_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp_c;
        int          cyc;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset crc", {16'h0, crc_o}, 32'h0000FFFF);
        check("R1 reset ready", {31'h0, ready_o}, 32'h1);
        check("R1 serial reset crc", {16'h0, s_crc_o}, 32'h0000FFFF);
        rst_n = 1'b1;

        // R3 R6 table walk on parallel, R8 on serial
        exp_c = 16'hFFFF;
        for (int k = 0; k < NV; k++) begin
            logic        sel;
            logic [1:0]  w;
            logic [31:0] d;
            {sel, w, d} = VEC[k];
            exp_c = sel ? d[15:0] : model(exp_c, d, w);
            pwr(sel, w, d);
            check("R6 R3 parallel vector", {16'h0, crc_o}, {16'h0, exp_c});
            check("R6 parallel ready", {31'h0, ready_o}, 32'h1);
            s_issue(sel, w, d);
            s_wait(cyc);
            check("R8 R3 serial vector", {16'h0, s_crc_o}, {16'h0, exp_c});
        end

        // R2 R4 known answer with mixed widths
        pwr(1'b1, 2'b00, 32'h0000FFFF);
        pwr(1'b0, 2'b11, 32'h31323334);
        pwr(1'b0, 2'b10, 32'h00003536);
        pwr(1'b0, 2'b01, 32'h00000037);
        pwr(1'b0, 2'b01, 32'h00000038);
        pwr(1'b0, 2'b01, 32'h00000039);
        check("R2 R4 known answer parallel", {16'h0, crc_o}, 32'h000029B1);
        s_issue(1'b1, 2'b00, 32'h0000FFFF);
        for (int b = 8'h31; b <= 8'h39; b++) begin
            s_issue(1'b0, 2'b01, 32'(b));
            s_wait(cyc);
        end
        check("R2 R4 known answer serial bytes", {16'h0, s_crc_o}, 32'h000029B1);

        // R7 hold while idle
        exp_c = crc_o;
        repeat (6) @(negedge clk);
        check("R7 idle hold", {16'h0, crc_o}, {16'h0, exp_c});

        // R8 busy length for 8-bit and 1-bit writes
        s_issue(1'b1, 2'b00, 32'h00001234);
        s_issue(1'b0, 2'b01, 32'h000000A5);
        s_wait(cyc);
        check("R8 busy cycles for 8-bit", 32'(cyc), 32'd7);
        check("R8 serial 8-bit result", {16'h0, s_crc_o}, {16'h0, model(16'h1234, 32'hA5, 2'b01)});
        s_issue(1'b0, 2'b00, 32'h00000001);
        check("R8 1-bit ready", {31'h0, s_ready_o}, 32'h1);
        check("R8 1-bit result", {16'h0, s_crc_o},
              {16'h0, model(model(16'h1234, 32'hA5, 2'b01), 32'h1, 2'b00)});

        // R9 write during busy ignored
        s_issue(1'b1, 2'b00, 32'h0000BEEF);
        s_issue(1'b0, 2'b11, 32'h12345678);
        s_issue(1'b0, 2'b10, 32'h0000FFFF);
        s_wait(cyc);
        check("R9 busy write ignored", {16'h0, s_crc_o},
              {16'h0, model(16'hBEEF, 32'h12345678, 2'b11)});

        // R5 seed cancels fold in progress
        s_issue(1'b0, 2'b11, 32'hCAFEF00D);
        s_issue(1'b1, 2'b00, 32'h00005A5A);
        check("R5 seed override crc", {16'h0, s_crc_o}, 32'h00005A5A);
        check("R5 seed override ready", {31'h0, s_ready_o}, 32'h1);
        repeat (3) @(negedge clk);
        check("R5 seed value kept", {16'h0, s_crc_o}, 32'h00005A5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule